// File: doc/BRIEF.md
# Masked Vector Element Compress Unit

This unit takes a vector of up to 512 bits, a per-element selection mask and a handful of mode controls. It gathers the selected elements into consecutive positions starting at element zero, and it keeps their original order. Elements are either bytes or 16-bit words. The active vector length is 128, 256 or 512 bits, so the number of elements considered ranges from 8 to 64. Masking can be switched off, and then every element inside the length is selected.

Two destinations are supported.

- **Register destination.** The part of the result above the packed elements, up to the vector length, is filled in one of two ways. In merging it comes from an old destination value. In zeroing it is cleared. Everything above the vector length is always cleared.
- **Memory store path.** The unit drives a per-byte write-enable that covers exactly the packed prefix, so no byte beyond it is written.

The unit also reports how many elements were packed. The result is registered and appears one clock after the request.

Top module: `vec_compress_unit`

## Requirements
- R1: `len_sel` selects the element count. Values 0, 1 and 2 give 16, 32 and 64 byte elements, or 8, 16 and 32 word elements. Value 3 behaves as 2. Mask bits at element indices at or above that count are ignored.
- R2: Element j is active when `mask[j]` is 1 or `mask_en` is 0. Active elements are copied, in ascending source order, to result element positions 0, 1, 2 and so on.
- R3: `count` (7 bits) equals the number of active elements, from 0 to 64.
- R4: In register mode with merging (`store_mode`=0, `zero_tail`=0), result bits from count×element width up to the vector length minus one equal `old_dst`.
- R5: In register mode with zeroing (`store_mode`=0, `zero_tail`=1), those same tail bits are 0.
- R6: In register mode, result bits at and above the selected vector length are 0.
- R7: In store mode, `byte_we[b]` is 1 exactly for b < count×(element width/8). All result bits above the packed prefix are 0, and `zero_tail` has no effect.
- R8: In register mode, `byte_we` is all zero.
- R9: After a request with `in_valid`=1, all outputs update at the next rising clock edge and `out_valid` is 1 for that cycle. Without a request, `out_valid` is 0 and the other outputs hold their values. Reset clears every output to 0.
- R10: In word mode (`word_mode`=1), element j is `src[16j+15:16j]` and its packed copy sets the two adjacent bits of `byte_we` that cover it. In byte mode, element j is `src[8j+7:8j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 512 | Source vector |
| mask | input | 64 | Per-element select, bit j for element j |
| mask_en | input | 1 | 0: every element within the length is active |
| word_mode | input | 1 | 0: byte elements, 1: 16-bit word elements |
| len_sel | input | 2 | 0: 128 bits, 1: 256 bits, 2 or 3: 512 bits |
| store_mode | input | 1 | 1: memory store path, 0: register destination |
| zero_tail | input | 1 | Register mode tail: 1 zeroes, 0 merges |
| old_dst | input | 512 | Old destination value used for merging |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Packed vector |
| count | output | 7 | Number of packed elements |
| byte_we | output | 64 | Per-byte write-enable of the packed prefix |

## Verification
The bench targets the following corner cases:

- **Empty mask.** With merging, a design that mishandles it would corrupt `old_dst` or leave stray write-enables.
- **Mask bits set only above the vector length.** A design that ignores the length would pack those elements and report a nonzero count.
- **`len_sel`=3.** A design that mishandles it would collapse to a short length.
- **Zeroing requested in store mode.** A design that honours it there would change the store result.

Word mode is compared against a sequential element-by-element reference for every length and mode. An off-by-one in the prefix, or a tail boundary computed in bytes instead of words, would shift or overwrite data.

A cycle without a request confirms that the registered outputs hold their values.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int MAX_BYTES = 64;

  // right shift applied to the full byte count for each length select
  function automatic int len_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/vcmp_lane_mask.sv
module vcmp_lane_mask #(
  parameter int NB = vcmp_pkg::MAX_BYTES
) (
  input  logic [NB-1:0] mask,
  input  logic          word_mode,
  input  logic [1:0]    len_sel,
  input  logic          mask_en,
  output logic [NB-1:0] act_bytes,
  output logic [NB-1:0] vl_bytes
);
  int lim;

  // expand the element mask to a byte mask limited to the vector length
  always_comb begin
    lim = NB >> vcmp_pkg::len_shift(len_sel);
    for (int b = 0; b < NB; b++) begin
      vl_bytes[b]  = (b < lim);
      act_bytes[b] = vl_bytes[b] &
                     (~mask_en | (word_mode ? mask[b/2] : mask[b]));
    end
  end
endmodule

// File: rtl/vcmp_byte_pack.sv
module vcmp_byte_pack #(
  parameter  int NB = vcmp_pkg::MAX_BYTES,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic [8*NB-1:0] src,
  input  logic [NB-1:0]   act_bytes,
  output logic [8*NB-1:0] packed_v,
  output logic [CW-1:0]   nbytes
);
  logic [CW-1:0] run;

  // word elements arrive as byte pairs with both bits set, so byte packing
  // keeps each pair adjacent and in order
  always_comb begin
    run      = '0;
    packed_v = '0;
    for (int j = 0; j < NB; j++) begin
      if (act_bytes[j]) begin
        packed_v[{run, 3'b000} +: 8] = src[8*j +: 8];
        run = run + 1'b1;
      end
    end
    nbytes = run;
  end
endmodule

// File: rtl/vcmp_tail_sel.sv
module vcmp_tail_sel #(
  parameter  int NB = vcmp_pkg::MAX_BYTES,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic [8*NB-1:0] packed_v,
  input  logic [8*NB-1:0] old_dst,
  input  logic [CW-1:0]   nbytes,
  input  logic [NB-1:0]   vl_bytes,
  input  logic            zero_tail,
  input  logic            store_mode,
  output logic [8*NB-1:0] result,
  output logic [NB-1:0]   byte_we
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic in_pre;
    logic keep_old;

    assign in_pre     = (CW'(b) < nbytes);
    assign keep_old   = ~store_mode & ~zero_tail & vl_bytes[b];
    assign byte_we[b] = store_mode & in_pre;
    assign result[8*b +: 8] = in_pre   ? packed_v[8*b +: 8] :
                              keep_old ? old_dst[8*b +: 8]  : 8'h00;
  end
endmodule

// File: rtl/vec_compress_unit.sv
module vec_compress_unit #(
  parameter  int NB = vcmp_pkg::MAX_BYTES,
  localparam int W  = 8 * NB,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  src,
  input  logic [NB-1:0] mask,
  input  logic          mask_en,
  input  logic          word_mode,
  input  logic [1:0]    len_sel,
  input  logic          store_mode,
  input  logic          zero_tail,
  input  logic [W-1:0]  old_dst,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic [CW-1:0] count,
  output logic [NB-1:0] byte_we
);
  logic [NB-1:0] act_bytes;
  logic [NB-1:0] vl_bytes;
  logic [W-1:0]  packed_v;
  logic [CW-1:0] nbytes;
  logic [W-1:0]  res_d;
  logic [NB-1:0] we_d;
  logic [CW-1:0] cnt_d;

  vcmp_lane_mask #(.NB(NB)) u_lane (
    .mask(mask), .word_mode(word_mode), .len_sel(len_sel), .mask_en(mask_en),
    .act_bytes(act_bytes), .vl_bytes(vl_bytes)
  );

  vcmp_byte_pack #(.NB(NB)) u_pack (
    .src(src), .act_bytes(act_bytes), .packed_v(packed_v), .nbytes(nbytes)
  );

  vcmp_tail_sel #(.NB(NB)) u_tail (
    .packed_v(packed_v), .old_dst(old_dst), .nbytes(nbytes), .vl_bytes(vl_bytes),
    .zero_tail(zero_tail), .store_mode(store_mode), .result(res_d), .byte_we(we_d)
  );

  assign cnt_d = word_mode ? (nbytes >> 1) : nbytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      count     <= '0;
      byte_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        count   <= cnt_d;
        byte_we <= we_d;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_reg_no_we: assert property (@(posedge clk) disable iff (rst)
    in_valid && !store_mode |=> byte_we == '0);
  a_r7_we_prefix: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((byte_we + 1'b1) & byte_we) == '0);
  a_r7_we_bytes_count: assert property (@(posedge clk) disable iff (rst)
    in_valid && store_mode && !word_mode |=> $countones(byte_we) == int'(count));
  a_r10_we_words_count: assert property (@(posedge clk) disable iff (rst)
    in_valid && store_mode && word_mode |=> $countones(byte_we) == 2 * int'(count));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && !store_mode && len_sel == 2'd0 |=> result[W-1:W/4] == '0);
  a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(count) <= NB);
endmodule

// File: tb/sim_vec_compress_unit.sv
module sim_vec_compress_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [63:0]  mask = '0;
  logic         mask_en = 1'b0;
  logic         word_mode = 1'b0;
  logic [1:0]   len_sel = 2'd0;
  logic         store_mode = 1'b0;
  logic         zero_tail = 1'b0;
  logic [511:0] old_dst = '0;
  logic         out_valid;
  logic [511:0] result;
  logic [6:0]   count;
  logic [63:0]  byte_we;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  vec_compress_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .mask(mask),
    .mask_en(mask_en), .word_mode(word_mode), .len_sel(len_sel),
    .store_mode(store_mode), .zero_tail(zero_tail), .old_dst(old_dst),
    .out_valid(out_valid), .result(result), .count(count), .byte_we(byte_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // sequential reference: walk elements, queue the selected ones, lay them out
  task automatic model(output logic [511:0] r, output int cnt, output logic [63:0] we);
    int ew  = word_mode ? 16 : 8;
    int ne  = (word_mode ? 8 : 16) << (len_sel == 2'd3 ? 2 : int'(len_sel));
    int vlb = ne * ew;
    int sel[$];
    r  = '0;
    we = '0;
    if (!store_mode && !zero_tail)
      for (int i = 0; i < vlb; i++) r[i] = old_dst[i];
    for (int j = 0; j < ne; j++)
      if (!mask_en || mask[j]) sel.push_back(j);
    foreach (sel[k])
      for (int i = 0; i < ew; i++) r[k*ew + i] = src[sel[k]*ew + i];
    cnt = sel.size();
    if (store_mode)
      for (int b = 0; b < cnt * ew / 8; b++) we[b] = 1'b1;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // one request: inputs already set at a falling edge
  task automatic run_one();
    logic [511:0] er;
    logic [63:0]  ew;
    int           ec;
    string        rtag;
    model(er, ec, ew);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rtag = store_mode ? "R7" : (zero_tail ? "R5" : "R4");
    chk(out_valid == 1'b1, "R9", "out_valid", 512'(out_valid), 512'(1));
    chk(result == er, word_mode ? "R10" : rtag, "result", result, er);
    chk(int'(count) == ec, "R3", "count", 512'(count), 512'(ec));
    chk(byte_we == ew, store_mode ? "R7" : "R8", "byte_we", 512'(byte_we), 512'(ew));
    if (!store_mode && len_sel == 2'd0)
      chk(result[511:128] == '0, "R6", "upper bits", result, er);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] hold_r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 0 && result == '0 && count == '0 && byte_we == '0,
        "R9", "reset state", result, '0);

    // empty mask, merge, full length: count 0, old value kept
    src = rnd512(); old_dst = rnd512(); mask = '0; mask_en = 1;
    word_mode = 0; len_sel = 2; store_mode = 0; zero_tail = 0;
    run_one();
    chk(result == old_dst, "R4", "empty mask keeps old", result, old_dst);
    // empty mask, store: no enables
    store_mode = 1; run_one();
    // masking disabled, words, 256 bits, zeroing: all 16 words
    mask_en = 0; word_mode = 1; len_sel = 1; store_mode = 0; zero_tail = 1;
    run_one();
    chk(count == 7'd16, "R2", "unmasked word count", 512'(count), 512'(16));
    // mask bits only above 128-bit length are ignored
    mask_en = 1; word_mode = 0; len_sel = 0; zero_tail = 0;
    mask = 64'hFFFF_FFFF_FFFF_0000;
    run_one();
    chk(count == 7'd0, "R1", "mask above length ignored", 512'(count), 512'(0));
    // length select 3 behaves as full length
    mask_en = 0; len_sel = 3; run_one();
    chk(count == 7'd64, "R1", "len_sel 3 full", 512'(count), 512'(64));
    // zeroing requested in store mode has no effect
    mask_en = 1; mask = 64'h8000_0000_0000_0001; store_mode = 1; zero_tail = 1;
    len_sel = 2; run_one();
    // idle cycle holds outputs
    hold_r = result;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 0, "R9", "idle out_valid", 512'(out_valid), 512'(0));
    chk(result == hold_r, "R9", "idle hold", result, hold_r);

    for (int wm = 0; wm < 2; wm++)
      for (int ls = 0; ls < 4; ls++)
        for (int md = 0; md < 4; md++)
          for (int it = 0; it < 15; it++) begin
            src = rnd512(); old_dst = rnd512();
            mask = {$urandom, $urandom};
            if (it == 0) mask = '1;
            if (it == 1) mask = '0;
            mask_en = (it != 2);
            word_mode = wm[0]; len_sel = ls[1:0];
            store_mode = (md >= 2); zero_tail = md[0];
            run_one();
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule